// File: doc/BRIEF.md
# Timer Status Register with Edge-Detected Interval Flags

This block holds the two sticky flags of a processor timer unit. One flag records fixed-interval expiries and the other records programmable-interval expiries. The fixed-interval flag is raised when one chosen bit of a free-running time-base counter goes from 0 to 1. A 2-bit select input picks that bit out of four evenly spaced taps. The programmable-interval flag is raised by a one-cycle timeout pulse from a decrementer.

Software reads both flags as one status word. To clear a flag, software writes a mask in which each 1 clears the matching flag and each 0 leaves it alone. A flag that is set in the same cycle as a clearing write stays set, so no expiry is lost. Each flag drives its own interrupt request. A request is asserted only when its flag, its own enable and the global external-interrupt enable are all high.

Top module: `tmr_status_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both flags and the edge history. After the edge, `status_word` reads 0 and both requests are low.
- R2: The fixed-interval flag is set at the second rising clock edge after the selected time-base tap goes from 0 to 1. A falling tap, or a tap held steady at 1, does not set it.
- R3: `fit_sel` = n selects time-base bit FIT_TAP_LO + n*FIT_TAP_STEP, which is bit 12, 16, 20 or 24 by default. A 0-to-1 change on any other tap does not set the flag.
- R4: The programmable-interval flag is set at the first rising clock edge at which `pit_timeout` is high.
- R5: When `wr_en` is high at a clock edge, each flag whose bit in `wr_mask` is 1 is cleared. Each flag whose mask bit is 0 keeps its value.
- R6: If a set event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R7: `fit_irq` equals fixed flag AND `fit_en` AND `ext_int_en`. `pit_irq` equals programmable flag AND `pit_en` AND `ext_int_en`. Both follow their inputs in the same cycle.
- R8: `status_word` carries the fixed flag at bit FIT_POS (default 2) and the programmable flag at bit PIT_POS (default 3). All other bits read 0, whatever has been written.
- R9: A set flag holds its value until a clearing write or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tb_bits | input | TB_W | Free-running time-base value |
| fit_sel | input | 2 | Selects the time-base tap for the fixed-interval flag |
| pit_timeout | input | 1 | Decrementer timeout pulse |
| wr_en | input | 1 | Status write strobe |
| wr_mask | input | DATA_W | Clear mask; a 1 clears the matching flag |
| fit_en | input | 1 | Fixed-interval interrupt enable |
| pit_en | input | 1 | Programmable-interval interrupt enable |
| ext_int_en | input | 1 | Global external-interrupt enable |
| status_word | output | DATA_W | Read-back of the flags |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| pit_irq | output | 1 | Programmable-interval interrupt request |

## Verification
Each result falls due at a fixed edge after its stimulus:
- A tap rise shows in the fixed flag after two rising edges.
- A timeout pulse or a clearing write takes effect after one edge.
- The requests follow a change of enable with no edge at all.

The bench drives inputs on the falling clock edge and counts edges explicitly. It samples the fixed flag both one edge and two edges after a tap rise, so a missing or an extra stage is caught. Request gating is sampled a short delay after the enables change, within the same half cycle. Set-against-clear collisions are lined up so that the write and the set event meet at the same rising edge.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
   localparam int NUM_TAPS  = 4;
   localparam int TAP_SEL_W = $clog2(NUM_TAPS);
   typedef logic [TAP_SEL_W-1:0] tap_sel_t;
endpackage

// File: rtl/tsr_tap_mux.sv
module tsr_tap_mux
   import tsr_pkg::*;
#(
   parameter int TB_W     = 64,
   parameter int TAP_LO   = 12,
   parameter int TAP_STEP = 4
) (
   input  logic [TB_W-1:0] tb_bits,
   input  tap_sel_t        sel,
   output logic            tap
);
   localparam int TAP_HI = TAP_LO + (NUM_TAPS-1)*TAP_STEP;

   if (TAP_STEP < 1) begin : g_bad_step
      $error("tsr_tap_mux: TAP_STEP must be at least 1");
   end
   if (TAP_HI >= TB_W || TAP_LO < 0) begin : g_bad_range
      $error("tsr_tap_mux: tap range exceeds time-base width");
   end

   logic [NUM_TAPS-1:0] taps;
   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      assign taps[i] = tb_bits[TAP_LO + i*TAP_STEP];
   end

   assign tap = taps[sel];
endmodule

// File: rtl/tsr_edge_det.sv
module tsr_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   logic cap_q;
   logic hist_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_q  <= 1'b0;
         hist_q <= 1'b0;
      end else begin
         cap_q  <= din;
         hist_q <= cap_q;
      end
   end

   assign rise = cap_q & ~hist_q;
endmodule

// File: rtl/tsr_sticky_bit.sv
module tsr_sticky_bit (
   input  logic clk,
   input  logic rst,
   input  logic set_evt,
   input  logic clr_req,
   output logic flag
);
   always_ff @(posedge clk) begin
      if (rst)
         flag <= 1'b0;
      else if (set_evt)
         flag <= 1'b1;
      else if (clr_req)
         flag <= 1'b0;
   end
endmodule

// File: rtl/tmr_status_reg.sv
module tmr_status_reg
   import tsr_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int TB_W         = 64,
   parameter int FIT_TAP_LO   = 12,
   parameter int FIT_TAP_STEP = 4,
   parameter int FIT_POS      = 2,
   parameter int PIT_POS      = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [TB_W-1:0]   tb_bits,
   input  logic [1:0]        fit_sel,
   input  logic              pit_timeout,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic              fit_en,
   input  logic              pit_en,
   input  logic              ext_int_en,
   output logic [DATA_W-1:0] status_word,
   output logic              fit_irq,
   output logic              pit_irq
);
   if (FIT_POS == PIT_POS) begin : g_bad_pos
      $error("tmr_status_reg: flag positions must differ");
   end
   if (FIT_POS >= DATA_W || PIT_POS >= DATA_W || FIT_POS < 0 || PIT_POS < 0) begin : g_bad_width
      $error("tmr_status_reg: flag position outside status word");
   end

   logic fit_tap;
   logic fit_rise;
   logic fit_flag;
   logic pit_flag;

   tsr_tap_mux #(
      .TB_W     (TB_W),
      .TAP_LO   (FIT_TAP_LO),
      .TAP_STEP (FIT_TAP_STEP)
   ) u_mux (
      .tb_bits (tb_bits),
      .sel     (tap_sel_t'(fit_sel)),
      .tap     (fit_tap)
   );

   tsr_edge_det u_edge (
      .clk  (clk),
      .rst  (rst),
      .din  (fit_tap),
      .rise (fit_rise)
   );

   tsr_sticky_bit u_fit (
      .clk     (clk),
      .rst     (rst),
      .set_evt (fit_rise),
      .clr_req (wr_en & wr_mask[FIT_POS]),
      .flag    (fit_flag)
   );

   tsr_sticky_bit u_pit (
      .clk     (clk),
      .rst     (rst),
      .set_evt (pit_timeout),
      .clr_req (wr_en & wr_mask[PIT_POS]),
      .flag    (pit_flag)
   );

   always_comb begin
      status_word          = '0;
      status_word[FIT_POS] = fit_flag;
      status_word[PIT_POS] = pit_flag;
   end

   assign fit_irq = fit_flag & fit_en & ext_int_en;
   assign pit_irq = pit_flag & pit_en & ext_int_en;
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
   parameter int DATA_W       = 32,
   parameter int TB_W         = 64,
   parameter int FIT_TAP_LO   = 12,
   parameter int FIT_TAP_STEP = 4,
   parameter int FIT_POS      = 2,
   parameter int PIT_POS      = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [TB_W-1:0]   tb_bits,
   input logic [1:0]        fit_sel,
   input logic              pit_timeout,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_mask,
   input logic              fit_en,
   input logic              pit_en,
   input logic              ext_int_en,
   input logic [DATA_W-1:0] status_word,
   input logic              fit_irq,
   input logic              pit_irq
);
   logic seen_q, seen_qq;
   logic tap_now;
   logic tap_rose;

   assign tap_now  = tb_bits[FIT_TAP_LO + int'(fit_sel)*FIT_TAP_STEP];
   assign tap_rose = seen_q & ~seen_qq;

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_q  <= 1'b0;
         seen_qq <= 1'b0;
      end else begin
         seen_q  <= tap_now;
         seen_qq <= seen_q;
      end
   end

   // R1
   p_reset_clear_r1: assert property (@(posedge clk) rst |=> (status_word == '0));

   // R2
   p_fit_set_r2: assert property (@(posedge clk) disable iff (rst)
      tap_rose |=> status_word[FIT_POS]);

   // R4
   p_pit_set_r4: assert property (@(posedge clk) disable iff (rst)
      pit_timeout |=> status_word[PIT_POS]);

   // R5
   p_mask_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mask[FIT_POS] && !tap_rose) |=> !status_word[FIT_POS]);

   // R6
   p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
      (pit_timeout && wr_en && wr_mask[PIT_POS]) |=> status_word[PIT_POS]);

   // R7
   p_fit_gate_r7: assert property (@(posedge clk) disable iff (rst)
      fit_irq |-> (fit_en && ext_int_en && status_word[FIT_POS]));
   p_pit_gate_r7: assert property (@(posedge clk) disable iff (rst)
      pit_irq |-> (pit_en && ext_int_en && status_word[PIT_POS]));

   // R9
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (status_word[PIT_POS] && !(wr_en && wr_mask[PIT_POS])) |=> status_word[PIT_POS]);
endmodule

bind tmr_status_reg tsr_checker #(
   .DATA_W       (DATA_W),
   .TB_W         (TB_W),
   .FIT_TAP_LO   (FIT_TAP_LO),
   .FIT_TAP_STEP (FIT_TAP_STEP),
   .FIT_POS      (FIT_POS),
   .PIT_POS      (PIT_POS)
) u_chk (.*);

// File: tb/tb_tmr_status_reg.sv
`timescale 1ns/1ps
module tb_tmr_status_reg;
   localparam int DW = 32;
   localparam int TW = 64;
   localparam int NV = 6;
   localparam logic [DW-1:0] VMASK [NV] = '{32'h0, 32'h4, 32'h8, 32'hC, 32'hFFFF_FFF3, 32'hFFFF_FFFF};
   localparam logic [DW-1:0] VEXP  [NV] = '{32'hC, 32'h8, 32'h4, 32'h0, 32'hC, 32'h0};

   logic          clk = 1'b0;
   logic          rst;
   logic [TW-1:0] tb_bits;
   logic [1:0]    fit_sel;
   logic          pit_timeout, wr_en, fit_en, pit_en, ext_int_en;
   logic [DW-1:0] wr_mask;
   logic [DW-1:0] status_word;
   logic          fit_irq, pit_irq;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   tmr_status_reg dut (
      .clk(clk), .rst(rst), .tb_bits(tb_bits), .fit_sel(fit_sel),
      .pit_timeout(pit_timeout), .wr_en(wr_en), .wr_mask(wr_mask),
      .fit_en(fit_en), .pit_en(pit_en), .ext_int_en(ext_int_en),
      .status_word(status_word), .fit_irq(fit_irq), .pit_irq(pit_irq)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [DW-1:0] m);
      wr_en = 1'b1; wr_mask = m;
      tick();
      wr_en = 1'b0; wr_mask = '0;
   endtask

   task automatic set_both(input int tap);
      tb_bits[tap] = 1'b1; pit_timeout = 1'b1;
      tick();
      pit_timeout = 1'b0;
      tick();
      tb_bits[tap] = 1'b0;
      tick(); tick();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; tb_bits = '0; fit_sel = 2'd0; pit_timeout = 1'b0;
      wr_en = 1'b0; wr_mask = '0; fit_en = 1'b1; pit_en = 1'b1; ext_int_en = 1'b1;
      tick(); tick(); tick();
      chk("R1 status after reset", status_word, 32'h0);
      chk("R1 irqs after reset", {30'b0, fit_irq, pit_irq}, 32'h0);
      rst = 1'b0;
      tick();

      // Vector table: set both flags, apply clear mask, compare (R5, R8)
      for (int i = 0; i < NV; i++) begin
         set_both(12);
         chk("R8 both set", status_word, 32'hC);
         wr(VMASK[i]);
         chk("R5 mask vector", status_word, VEXP[i]);
         wr(32'hFFFF_FFFF);
      end

      // R2 latency on tap 12
      tb_bits[12] = 1'b1;
      tick();
      chk("R2 one edge after rise", status_word, 32'h0);
      tick();
      chk("R2 two edges after rise", status_word, 32'h4);
      wr(32'h4);
      tick(); tick(); tick();
      chk("R2 steady high no set", status_word, 32'h0);
      tb_bits[12] = 1'b0;
      tick(); tick(); tick();
      chk("R2 falling no set", status_word, 32'h0);

      // R3 tap select
      fit_sel = 2'd2;
      tb_bits[12] = 1'b1; tb_bits[16] = 1'b1; tb_bits[24] = 1'b1;
      tick(); tick(); tick();
      chk("R3 unselected taps", status_word, 32'h0);
      tb_bits[12] = 1'b0; tb_bits[16] = 1'b0; tb_bits[24] = 1'b0;
      tick();
      tb_bits[20] = 1'b1;
      tick(); tick();
      chk("R3 selected tap 20", status_word, 32'h4);
      tb_bits[20] = 1'b0;
      wr(32'h4);
      tick(); tick();
      fit_sel = 2'd3;
      tick();
      tb_bits[24] = 1'b1;
      tick(); tick();
      chk("R3 selected tap 24", status_word, 32'h4);
      tb_bits[24] = 1'b0;
      wr(32'h4);
      tick(); tick();
      fit_sel = 2'd0;
      tick();

      // R4 pit latency
      pit_timeout = 1'b1;
      #1;
      chk("R4 before edge", status_word, 32'h0);
      tick();
      pit_timeout = 1'b0;
      chk("R4 after one edge", status_word, 32'h8);

      // R9 hold and zero-mask write
      tick(); tick(); tick(); tick();
      chk("R9 hold", status_word, 32'h8);
      wr(32'h0);
      chk("R9 zero mask keeps", status_word, 32'h8);
      wr(32'h8);
      chk("R5 clear pit", status_word, 32'h0);

      // R6 set wins, programmable flag
      pit_timeout = 1'b1; wr_en = 1'b1; wr_mask = 32'h8;
      tick();
      pit_timeout = 1'b0; wr_en = 1'b0; wr_mask = '0;
      chk("R6 pit set beats clear", status_word, 32'h8);
      wr(32'h8);

      // R6 set wins, fixed flag: write lands on the edge that sets it
      tb_bits[12] = 1'b1;
      tick();
      wr(32'h4);
      chk("R6 fit set beats clear", status_word, 32'h4);
      tb_bits[12] = 1'b0;
      wr(32'h4);
      tick(); tick();

      // R7 request gating
      set_both(12);
      for (int c = 0; c < 8; c++) begin
         fit_en = c[0]; pit_en = c[1]; ext_int_en = c[2];
         #1;
         chk("R7 fit_irq gate", {31'b0, fit_irq}, {31'b0, c[0] & c[2]});
         chk("R7 pit_irq gate", {31'b0, pit_irq}, {31'b0, c[1] & c[2]});
         tick();
      end
      fit_en = 1'b1; pit_en = 1'b1; ext_int_en = 1'b1;
      wr(32'hC);
      #1;
      chk("R7 no request when clear", {30'b0, fit_irq, pit_irq}, 32'h0);

      // R1 reset mid-operation
      tick();
      set_both(12);
      rst = 1'b1;
      tick();
      rst = 1'b0;
      chk("R1 reset clears flags", status_word, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule